// File: doc/BRIEF.md
# Strided Transfer Request Generator

This block turns a programmed three-level strided copy into two streams of bus requests: one for reads and one for writes. A copy is described by three counts. The byte count sets the bytes in one array. The array count sets the arrays in one frame. The frame count sets the number of frames. Each side, source and destination, has its own start address, its own step between arrays and its own step between frames. The data path, buffering and the bus fabric sit outside this block. It only produces addresses and lengths, each with a valid/ready handshake, and it pulses a completion strobe when the copy is finished.

Software loads the parameters and pulses `start`. Each `trig` pulse then releases one unit of work. In frame mode a unit is one whole frame. In array mode a unit is a single array. Source and destination are judged for contiguity on their own. A side whose array step equals the byte count is linear: within a frame-mode unit, its arrays are fused into one run. A side with a larger step issues one request per array. As a result, a byte-interleaved source can be gathered with narrow reads while the destination still receives long bursts. Every run is cut into chunks no longer than `MAX_BURST_BYTES`, and no chunk crosses an aligned boundary of that size.

Top module: `strided_req_gen`

## Requirements
- R1: After reset, `rd_valid`, `wr_valid` and `done` are all low.
- R2: On a side that is not merged, array k of frame c starts at that side's start address plus c times its frame step plus k times its array step, and it covers exactly the byte count.
- R3: When a side's array step differs from the byte count, every array on that side gets its own requests. For example, byte count 1 with source step 2 yields reads of length 1 at every second address.
- R4: In frame mode, a side whose array step equals the byte count issues the whole frame as one run starting at the frame's base address. The other side's stride has no effect on this.
- R5: Every request has a length from 1 to `MAX_BURST_BYTES`. Its address offset within a `MAX_BURST_BYTES`-aligned block plus its length never exceeds `MAX_BURST_BYTES`. Within one run, each chunk is as long as these limits allow.
- R6: While `rd_valid` or `wr_valid` is high and the matching ready is low, the valid signal, address and length stay unchanged in the next cycle.
- R7: In frame mode one trigger releases exactly one frame. In array mode one trigger releases exactly one array, and arrays are never fused, even on a linear side.
- R8: `trig` has no effect while no copy is in progress. `start` has no effect while a copy is in progress.
- R9: `done` is high for exactly one cycle, after every read and write request of the last unit has been accepted. No request is pending while `done` is high, and the block is idle afterwards.
- R10: If any of the three counts is zero, `done` pulses without any request being issued.
- R11: Frame c on each side starts at that side's start address plus c times that side's frame step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Latch the parameters and begin a copy (idle only) |
| trig | input | 1 | Release the next unit of work |
| frame_mode | input | 1 | 1: one trigger per frame, 0: one trigger per array |
| acnt | input | CW | Bytes per array |
| bcnt | input | CW | Arrays per frame |
| ccnt | input | CW | Frames per copy |
| src_addr | input | AW | Source start address |
| dst_addr | input | AW | Destination start address |
| src_astep | input | AW | Source step between arrays |
| dst_astep | input | AW | Destination step between arrays |
| src_fstep | input | AW | Source step between frames |
| dst_fstep | input | AW | Destination step between frames |
| rd_valid | output | 1 | Read request valid |
| rd_addr | output | AW | Read request address |
| rd_len | output | log2(MAX_BURST_BYTES)+1 | Read request length in bytes |
| rd_ready | input | 1 | Read request accepted |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | AW | Write request address |
| wr_len | output | log2(MAX_BURST_BYTES)+1 | Write request length in bytes |
| wr_ready | input | 1 | Write request accepted |
| done | output | 1 | One-cycle completion pulse |

## Verification
The key case is the byte gather: byte count 1, source step 2, destination step 1, 64 arrays, one frame. Here the destination is placed 16 bytes past an aligned block. A design that merged the strided side would produce a few wide reads instead of 64 single-byte reads, and a design that ignored the linear side would produce 64 one-byte writes instead of a 48-byte write followed by a 16-byte write. Runs longer than the burst cap and frame steps test chunk splitting and the per-frame base; a wrong boundary calculation shows up as a chunk that crosses a block boundary. Single trigger pulses in both modes expose a design that releases too much work per trigger or that fuses arrays in array mode. Stray `start` and `trig` pulses, zero counts and random ready stalls target a design that restarts mid-copy, issues requests on a null copy, or drifts its address while stalled.

// File: rtl/strided_req_gen.sv
module strided_req_gen #(
  parameter int AW = 32,
  parameter int CW = 16,
  parameter int MAX_BURST_BYTES = 64
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic                               trig,
  input  logic                               frame_mode,
  input  logic [CW-1:0]                      acnt,
  input  logic [CW-1:0]                      bcnt,
  input  logic [CW-1:0]                      ccnt,
  input  logic [AW-1:0]                      src_addr,
  input  logic [AW-1:0]                      dst_addr,
  input  logic [AW-1:0]                      src_astep,
  input  logic [AW-1:0]                      dst_astep,
  input  logic [AW-1:0]                      src_fstep,
  input  logic [AW-1:0]                      dst_fstep,
  output logic                               rd_valid,
  output logic [AW-1:0]                      rd_addr,
  output logic [$clog2(MAX_BURST_BYTES):0]   rd_len,
  input  logic                               rd_ready,
  output logic                               wr_valid,
  output logic [AW-1:0]                      wr_addr,
  output logic [$clog2(MAX_BURST_BYTES):0]   wr_len,
  input  logic                               wr_ready,
  output logic                               done
);
  localparam int OW = $clog2(MAX_BURST_BYTES);
  localparam int LW = OW + 1;
  localparam int RW = 2 * CW;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} st_t;
  st_t st;

  logic [CW-1:0] r_acnt, r_bcnt, r_ccnt, b_idx, c_idx;
  logic          r_fm;
  logic [AW-1:0] in_a [2], in_s [2], in_f [2];
  logic [AW-1:0] astep [2], fstep [2], frm [2], arr [2], cur [2];
  logic [RW-1:0] rem [2], rlen [2];
  logic [CW-1:0] left [2];
  logic [LW-1:0] room [2], clen [2];
  logic [1:0]    busy, lin, hs;
  logic          null_req, last_unit, frame_end;

  assign in_a[0] = src_addr;  assign in_a[1] = dst_addr;
  assign in_s[0] = src_astep; assign in_s[1] = dst_astep;
  assign in_f[0] = src_fstep; assign in_f[1] = dst_fstep;

  assign null_req  = (acnt == '0) || (bcnt == '0) || (ccnt == '0);
  assign frame_end = r_fm || (b_idx == r_bcnt - 1'b1);
  assign last_unit = (c_idx == r_ccnt - 1'b1) && frame_end;

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      lin[s]  = (AW'(r_acnt) == astep[s]);
      rlen[s] = (r_fm && lin[s]) ? RW'(r_acnt) * RW'(r_bcnt) : RW'(r_acnt);
      room[s] = LW'(MAX_BURST_BYTES) - LW'(cur[s][OW-1:0]);
      clen[s] = (rem[s] < RW'(room[s])) ? LW'(rem[s]) : room[s];
    end
  end

  assign rd_valid = busy[0];
  assign rd_addr  = cur[0];
  assign rd_len   = clen[0];
  assign wr_valid = busy[1];
  assign wr_addr  = cur[1];
  assign wr_len   = clen[1];
  assign hs       = {wr_valid && wr_ready, rd_valid && rd_ready};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      busy   <= '0;
      r_acnt <= '0;
      r_bcnt <= '0;
      r_ccnt <= '0;
      r_fm   <= 1'b0;
      b_idx  <= '0;
      c_idx  <= '0;
      for (int s = 0; s < 2; s++) begin
        astep[s] <= '0;
        fstep[s] <= '0;
        frm[s]   <= '0;
        arr[s]   <= '0;
        cur[s]   <= '0;
        rem[s]   <= '0;
        left[s]  <= '0;
      end
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          r_acnt <= acnt;
          r_bcnt <= bcnt;
          r_ccnt <= ccnt;
          r_fm   <= frame_mode;
          b_idx  <= '0;
          c_idx  <= '0;
          for (int s = 0; s < 2; s++) begin
            astep[s] <= in_s[s];
            fstep[s] <= in_f[s];
            frm[s]   <= in_a[s];
            arr[s]   <= in_a[s];
          end
          if (null_req) done <= 1'b1;
          else          st   <= S_WAIT;
        end
        S_WAIT: if (trig) begin
          for (int s = 0; s < 2; s++) begin
            cur[s]  <= arr[s];
            rem[s]  <= rlen[s];
            left[s] <= (r_fm && !lin[s]) ? r_bcnt - 1'b1 : '0;
          end
          busy <= 2'b11;
          st   <= S_RUN;
        end
        S_RUN: begin
          if (busy == 2'b00) begin
            if (last_unit) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              st <= S_WAIT;
              if (frame_end) begin
                b_idx <= '0;
                c_idx <= c_idx + 1'b1;
                for (int s = 0; s < 2; s++) begin
                  frm[s] <= frm[s] + fstep[s];
                  arr[s] <= frm[s] + fstep[s];
                end
              end else begin
                b_idx <= b_idx + 1'b1;
                for (int s = 0; s < 2; s++) arr[s] <= arr[s] + astep[s];
              end
            end
          end else begin
            for (int s = 0; s < 2; s++) begin
              if (hs[s]) begin
                if (rem[s] == RW'(clen[s])) begin
                  if (left[s] != '0) begin
                    arr[s]  <= arr[s] + astep[s];
                    cur[s]  <= arr[s] + astep[s];
                    rem[s]  <= RW'(r_acnt);
                    left[s] <= left[s] - 1'b1;
                  end else begin
                    busy[s] <= 1'b0;
                  end
                end else begin
                  cur[s] <= cur[s] + AW'(clen[s]);
                  rem[s] <= rem[s] - RW'(clen[s]);
                end
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/strided_req_gen_chk.sv
module strided_req_gen_chk #(
  parameter int AW = 32,
  parameter int MAX_BURST_BYTES = 64
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             rd_valid,
  input logic                             rd_ready,
  input logic [AW-1:0]                    rd_addr,
  input logic [$clog2(MAX_BURST_BYTES):0] rd_len,
  input logic                             wr_valid,
  input logic                             wr_ready,
  input logic [AW-1:0]                    wr_addr,
  input logic [$clog2(MAX_BURST_BYTES):0] wr_len,
  input logic                             done
);
  localparam int OW = $clog2(MAX_BURST_BYTES);

  // R6
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_addr) && $stable(rd_len));

  // R6
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_len));

  // R5
  rd_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_len != '0) && (int'(rd_addr[OW-1:0]) + int'(rd_len) <= MAX_BURST_BYTES));

  // R5
  wr_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_len != '0) && (int'(wr_addr[OW-1:0]) + int'(wr_len) <= MAX_BURST_BYTES));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !rd_valid && !wr_valid);
endmodule

bind strided_req_gen strided_req_gen_chk #(.AW(AW), .MAX_BURST_BYTES(MAX_BURST_BYTES)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_len(rd_len),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_len(wr_len),
  .done(done)
);

// File: tb/sim_strided_req_gen.sv
`timescale 1ns/1ps
module sim_strided_req_gen;
  typedef struct packed {logic [31:0] a; logic [7:0] l;} item_t;

  logic clk = 0, rst_n = 0, start = 0, trig = 0, frame_mode = 0;
  logic [15:0] acnt = 0, bcnt = 0, ccnt = 0;
  logic [31:0] src_addr = 0, dst_addr = 0, src_astep = 0, dst_astep = 0, src_fstep = 0, dst_fstep = 0;
  logic rd_valid, wr_valid, rd_ready = 0, wr_ready = 0, done;
  logic [31:0] rd_addr, wr_addr;
  logic [6:0] rd_len, wr_len;

  item_t rq[$], wq[$];
  int n_chk = 0, n_bad = 0, done_cnt = 0, cyc = 0;
  string tag = "R1";

  always #10 clk = ~clk;

  strided_req_gen u0 (.*);

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push_run(input int side, input logic [31:0] a, input int n);
    while (n > 0) begin
      int room = 64 - int'(a[5:0]);
      int l = (n < room) ? n : room;
      item_t it;
      it.a = a; it.l = 8'(l);
      if (side == 0) rq.push_back(it); else wq.push_back(it);
      a += 32'(l); n -= l;
    end
  endtask

  task automatic model();
    for (int c = 0; c < int'(ccnt); c++) begin
      for (int s = 0; s < 2; s++) begin
        logic [31:0] base = (s == 0) ? src_addr + 32'(c) * src_fstep : dst_addr + 32'(c) * dst_fstep;
        logic [31:0] st = (s == 0) ? src_astep : dst_astep;
        if (frame_mode && st == 32'(acnt)) push_run(s, base, int'(acnt) * int'(bcnt));
        else for (int b = 0; b < int'(bcnt); b++) push_run(s, base + 32'(b) * st, int'(acnt));
      end
    end
  endtask

  task automatic setup(input logic fm, input logic [31:0] sa, da, input int ac, bc, cc,
                       input logic [31:0] sb, db, sf, df);
    frame_mode = fm; src_addr = sa; dst_addr = da; acnt = 16'(ac); bcnt = 16'(bc); ccnt = 16'(cc);
    src_astep = sb; dst_astep = db; src_fstep = sf; dst_fstep = df;
  endtask

  task automatic begin_xfer();
    model();
    @(negedge clk) start = 1;
    @(negedge clk) start = 0;
  endtask

  task automatic finish_xfer(input string req);
    int d0 = done_cnt;
    int g = 0;
    trig = 1;
    while (done_cnt == d0 && g < 20000) begin @(negedge clk); g++; end
    trig = 0;
    chk(done_cnt == d0 + 1, req, "done count", done_cnt - d0, 1);
  endtask

  task automatic pulse_trig();
    @(negedge clk) trig = 1;
    @(negedge clk) trig = 0;
  endtask

  always @(negedge clk) begin
    item_t e;
    rd_ready = ($urandom % 4) != 0;
    wr_ready = ($urandom % 3) != 0;
    if (rst_n) begin
      if (rd_valid && rd_ready) begin
        if (rq.size() == 0) chk(0, tag, "unexpected read addr", rd_addr, 0);
        else begin
          e = rq.pop_front();
          chk(rd_addr == e.a, tag, "read addr", rd_addr, e.a);
          chk(8'(rd_len) == e.l, tag, "read len", rd_len, e.l);
        end
      end
      if (wr_valid && wr_ready) begin
        if (wq.size() == 0) chk(0, tag, "unexpected write addr", wr_addr, 0);
        else begin
          e = wq.pop_front();
          chk(wr_addr == e.a, tag, "write addr", wr_addr, e.a);
          chk(8'(wr_len) == e.l, tag, "write len", wr_len, e.l);
        end
      end
      if (done) begin
        done_cnt++;
        // R9: every expected request consumed before the pulse
        chk(rq.size() == 0 && wq.size() == 0, "R9", "pending items at done", rq.size() + wq.size(), 0);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk); cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected fewer than 150000", cyc);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(!rd_valid && !wr_valid && !done, "R1", "outputs in reset", {rd_valid, wr_valid, done}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!rd_valid && !wr_valid && !done, "R1", "outputs after reset", {rd_valid, wr_valid, done}, 0);

    // R3 / R4: byte gather into a linear destination, destination offset 16 into a block
    tag = "R3";
    setup(1, 32'h100, 32'h2010, 1, 64, 1, 2, 1, 0, 0);
    begin_xfer();
    chk(rq.size() == 64 && wq.size() == 2, "R4", "model item count", rq.size() * 100 + wq.size(), 6402);
    finish_xfer("R3");

    // R5 / R11 / R2: long linear source runs, strided destination, two frames
    tag = "R5";
    setup(1, 32'h20, 32'h4000, 100, 3, 2, 100, 128, 32'h1000, 32'h800);
    begin_xfer();
    finish_xfer("R11");

    // R2: both sides strided, three frames
    tag = "R2";
    setup(1, 32'h3, 32'h9005, 5, 4, 3, 9, 7, 32'h200, 32'h100);
    begin_xfer();
    finish_xfer("R2");

    // R7: frame mode, one trigger moves one frame; stray start ignored (R8)
    tag = "R7";
    setup(1, 32'h600, 32'h700, 2, 4, 2, 4, 2, 32'h40, 32'h20);
    begin_xfer();
    pulse_trig();
    repeat (60) @(negedge clk);
    chk(rq.size() == 4 && wq.size() == 1, "R7", "left after one frame trigger", rq.size() * 100 + wq.size(), 401);
    src_addr = 32'hDEAD0; start = 1;
    @(negedge clk) start = 0;
    src_addr = 32'h600;
    repeat (20) @(negedge clk);
    chk(!rd_valid && !wr_valid, "R8", "start mid-copy released work", {rd_valid, wr_valid}, 0);
    finish_xfer("R7");

    // R7: array mode never fuses arrays, one trigger one array
    setup(0, 32'h600, 32'h700, 2, 4, 2, 4, 2, 32'h40, 32'h20);
    begin_xfer();
    pulse_trig();
    repeat (40) @(negedge clk);
    chk(rq.size() == 7 && wq.size() == 7, "R7", "left after one array trigger", rq.size() * 100 + wq.size(), 707);
    finish_xfer("R7");

    // R8: triggers while idle do nothing
    tag = "R8";
    trig = 1;
    repeat (10) @(negedge clk);
    trig = 0;
    repeat (10) @(negedge clk);
    chk(!rd_valid && !wr_valid && !done, "R8", "activity after idle trigger", {rd_valid, wr_valid, done}, 0);

    // R10: null copies
    tag = "R10";
    setup(1, 32'h0, 32'h0, 4, 0, 2, 4, 4, 0, 0);
    begin_xfer();
    finish_xfer("R10");
    setup(0, 32'h0, 32'h0, 0, 3, 2, 4, 4, 0, 0);
    begin_xfer();
    finish_xfer("R10");
    chk(!rd_valid && !wr_valid, "R10", "requests on null copy", {rd_valid, wr_valid}, 0);

    repeat (5) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule